// File: doc/BRIEF.md
# Keyboard controller host register interface

This block is the bus-facing register set of a keyboard controller that follows the classic two-port PC keyboard scheme. A host on a simple asynchronous bus with active-low read and write strobes reaches two port addresses. Writes to the data port or to the command port both land in a single input buffer, and the port that was used is recorded in a command/data flag. Reads of the data port return the output buffer. Reads of the command port return a status byte.

On the other side, an embedded controller sees a small register-mapped port with single-cycle read and write strobes. Through it the controller drains the input buffer, loads the output buffer and programs a control byte. The control byte holds the interrupt enable, automatic flag clearing on host data reads, and the choice of keyboard or auxiliary (mouse) interrupt. The controller can also clear the output-buffer flag and the interrupts by software.

The host strobes are synchronized to the block clock. Each register action happens exactly once, on the asserting edge of a strobe.

Top module: `kbd_host_if`

## Requirements
- R1: After reset the status byte is 0x00, both interrupt outputs are low, the output and input buffers hold 0x00 and the control byte reads 0x00.
- R2: A host read at DATA_PORT returns the output buffer. A host read at CMD_PORT returns the status byte, whose fields are bit0 OBF, bit1 IBF, bit3 C/D and bit5 AUX, with every other bit 0. A read at any other address returns 0xFF, and strobes at any other address change no state.
- R3: A host write at DATA_PORT loads the input buffer, sets IBF and clears C/D to 0.
- R4: A host write at CMD_PORT loads the input buffer, sets IBF and sets C/D to 1.
- R5: A controller read at ctl_addr 0 (ctl_rd high) returns the input buffer and clears IBF. If a host write takes effect in the same cycle, IBF stays set.
- R6: A controller write at ctl_addr 0 loads the output buffer, sets OBF and copies the aux-select bit into AUX. When the irq-enable bit is 1, it raises kbd_irq if aux-select is 0 and aux_irq if aux-select is 1; when irq-enable is 0 neither interrupt rises. A write while OBF is already set replaces the buffer and OBF stays 1.
- R7: When the auto-clear bit is 1, a host data-port read clears OBF, AUX, kbd_irq and aux_irq. When the auto-clear bit is 0, that read leaves all four unchanged. In both cases the output buffer itself is kept.
- R8: A controller write at ctl_addr 3 clears OBF, AUX, kbd_irq and aux_irq. A controller output-buffer write in the same cycle as an auto-clearing host read leaves OBF set.
- R9: A host status read changes no flag, buffer or interrupt.
- R10: A host strobe acts once, SYNC_STAGES+1 clock edges after it falls. Holding it low does not repeat the action.
- R11: The control byte is written and read at ctl_addr 2, with bit0 auto-clear, bit1 irq-enable and bit2 aux-select, and upper bits reading 0. ctl_addr 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Host port address, stable while a strobe is low |
| bus_wdata | input | 8 | Host write data, stable while the write strobe is low |
| bus_rdata | output | 8 | Host read data for the addressed port |
| bus_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| bus_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| ctl_addr | input | 2 | Controller register select |
| ctl_wr | input | 1 | Controller write strobe, one cycle |
| ctl_rd | input | 1 | Controller read strobe, one cycle |
| ctl_wdata | input | 8 | Controller write data |
| ctl_rdata | output | 8 | Controller read data for ctl_addr |
| kbd_irq | output | 1 | Keyboard interrupt |
| aux_irq | output | 1 | Auxiliary (mouse) interrupt |

## Verification
The bench builds the block with ADDR_W=10 and SYNC_STAGES=3, ports 0x60 and 0x64. The narrow address space lets random unmapped addresses be drawn often. The deeper synchronizer shows that the fixed strobe timing in the bench does not depend on the default latency. Random interleavings of host and controller accesses, and of control-byte values, reach both auto-clear settings and both interrupt routes. Directed cases cover overwrite while OBF is set, and a strobe held low across a fresh output-buffer write.

// File: rtl/kbd_host_pkg.sv
package kbd_host_pkg;

  typedef enum logic [1:0] {
    PORT_NONE = 2'd0,
    PORT_DATA = 2'd1,
    PORT_CMD  = 2'd2
  } host_port_e;

  typedef struct packed {
    logic aux;
    logic cd;
    logic ibf;
    logic obf;
  } kbd_flags_t;

  localparam logic [1:0] CTL_DATA = 2'd0;
  localparam logic [1:0] CTL_STAT = 2'd1;
  localparam logic [1:0] CTL_CTRL = 2'd2;
  localparam logic [1:0] CTL_CLR  = 2'd3;

  // Status byte layout: bit0 OBF, bit1 IBF, bit3 C/D, bit5 AUX
  function automatic logic [7:0] pack_status(input kbd_flags_t f);
    return {2'b00, f.aux, 1'b0, f.cd, 1'b0, f.ibf, f.obf};
  endfunction

  function automatic host_port_e decode_port(input logic [31:0] addr,
                                             input logic [31:0] data_port,
                                             input logic [31:0] cmd_port);
    if (addr == data_port) return PORT_DATA;
    if (addr == cmd_port)  return PORT_CMD;
    return PORT_NONE;
  endfunction

endpackage

// File: rtl/kbd_strobe_sync.sv
module kbd_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_pulse
);
  localparam int W = STAGES + 1;

  logic [W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= {shift_q[W-2:0], strobe_n};
  end

  assign fall_pulse = shift_q[W-1] & ~shift_q[W-2];

  // R10: a falling pulse lasts exactly one cycle
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);

endmodule

// File: rtl/kbd_flag_core.sv
module kbd_flag_core
  import kbd_host_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_fall,
  input  logic              hr_fall,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [1:0]        ctl_addr,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  output logic              kbd_irq,
  output logic              aux_irq
);
  host_port_e hport;
  kbd_flags_t flags_q;
  logic [7:0] ibuf_q, obuf_q, status;
  logic       auto_en_q, irq_en_q, aux_sel_q;

  assign hport  = decode_port(32'(bus_addr), 32'(DATA_PORT), 32'(CMD_PORT));
  assign status = pack_status(flags_q);

  // Named events
  logic host_data_wr_evt, host_cmd_wr_evt, host_data_rd_evt, host_stat_rd_evt;
  logic host_none_evt, host_any_wr_evt;
  logic ctl_obuf_wr_evt, ctl_ibuf_rd_evt, ctl_ctrl_wr_evt, ctl_swclr_evt;
  logic obuf_clr_evt, ctl_quiet;

  assign host_data_wr_evt = hw_fall && (hport == PORT_DATA);
  assign host_cmd_wr_evt  = hw_fall && (hport == PORT_CMD);
  assign host_data_rd_evt = hr_fall && (hport == PORT_DATA);
  assign host_stat_rd_evt = hr_fall && (hport == PORT_CMD);
  assign host_none_evt    = (hw_fall || hr_fall) && (hport == PORT_NONE);
  assign host_any_wr_evt  = host_data_wr_evt || host_cmd_wr_evt;

  assign ctl_obuf_wr_evt  = ctl_wr && (ctl_addr == CTL_DATA);
  assign ctl_ctrl_wr_evt  = ctl_wr && (ctl_addr == CTL_CTRL);
  assign ctl_swclr_evt    = ctl_wr && (ctl_addr == CTL_CLR);
  assign ctl_ibuf_rd_evt  = ctl_rd && (ctl_addr == CTL_DATA);
  assign ctl_quiet        = !ctl_wr && !ctl_rd;

  assign obuf_clr_evt     = ctl_swclr_evt || (host_data_rd_evt && auto_en_q);

  // Input side: host writes, controller drains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibuf_q      <= '0;
      flags_q.ibf <= 1'b0;
      flags_q.cd  <= 1'b0;
    end else if (host_any_wr_evt) begin
      ibuf_q      <= bus_wdata;
      flags_q.ibf <= 1'b1;
      flags_q.cd  <= host_cmd_wr_evt;
    end else if (ctl_ibuf_rd_evt) begin
      flags_q.ibf <= 1'b0;
    end
  end

  // Output side: controller loads, host read or software clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      obuf_q      <= '0;
      flags_q.obf <= 1'b0;
      flags_q.aux <= 1'b0;
      kbd_irq     <= 1'b0;
      aux_irq     <= 1'b0;
    end else if (ctl_obuf_wr_evt) begin
      obuf_q      <= ctl_wdata;
      flags_q.obf <= 1'b1;
      flags_q.aux <= aux_sel_q;
      kbd_irq     <= irq_en_q && !aux_sel_q;
      aux_irq     <= irq_en_q && aux_sel_q;
    end else if (obuf_clr_evt) begin
      flags_q.obf <= 1'b0;
      flags_q.aux <= 1'b0;
      kbd_irq     <= 1'b0;
      aux_irq     <= 1'b0;
    end
  end

  // Control byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
      aux_sel_q <= 1'b0;
    end else if (ctl_ctrl_wr_evt) begin
      auto_en_q <= ctl_wdata[0];
      irq_en_q  <= ctl_wdata[1];
      aux_sel_q <= ctl_wdata[2];
    end
  end

  // Read muxes
  always_comb begin
    unique case (hport)
      PORT_DATA: bus_rdata = obuf_q;
      PORT_CMD:  bus_rdata = status;
      default:   bus_rdata = 8'hFF;
    endcase
  end

  always_comb begin
    unique case (ctl_addr)
      CTL_DATA: ctl_rdata = ibuf_q;
      CTL_STAT: ctl_rdata = status;
      CTL_CTRL: ctl_rdata = {5'b0, aux_sel_q, irq_en_q, auto_en_q};
      default:  ctl_rdata = 8'h00;
    endcase
  end

  // R3
  data_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_data_wr_evt |=> flags_q.ibf && !flags_q.cd && ibuf_q == $past(bus_wdata));
  // R4
  cmd_wr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_wr_evt |=> flags_q.ibf && flags_q.cd);
  // R5
  ibuf_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_ibuf_rd_evt && !host_any_wr_evt) |=> !flags_q.ibf);
  // R6
  obuf_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_obuf_wr_evt |=> flags_q.obf);
  // R6
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_irq, aux_irq}));
  // R7
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_rd_evt && auto_en_q && !ctl_obuf_wr_evt)
      |=> !flags_q.obf && !kbd_irq && !aux_irq);
  // R7
  no_auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_data_rd_evt && !auto_en_q && !hw_fall && ctl_quiet)
      |=> $stable(status) && $stable(kbd_irq) && $stable(aux_irq));
  // R8
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_swclr_evt |=> !flags_q.obf && !kbd_irq && !aux_irq);
  // R9
  status_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stat_rd_evt && !hw_fall && ctl_quiet)
      |=> $stable(status) && $stable(obuf_q) && $stable(ibuf_q));
  // R2
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_none_evt && ctl_quiet) |=> $stable(status) && $stable(ibuf_q));

endmodule

// File: rtl/kbd_host_if.sv
module kbd_host_if #(
  parameter int ADDR_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
  parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bus_rd_n,
  input  logic              bus_wr_n,
  input  logic [1:0]        ctl_addr,
  input  logic              ctl_wr,
  input  logic              ctl_rd,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  output logic              kbd_irq,
  output logic              aux_irq
);
  logic hw_fall, hr_fall;

  kbd_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(bus_wr_n), .fall_pulse(hw_fall));

  kbd_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .strobe_n(bus_rd_n), .fall_pulse(hr_fall));

  kbd_flag_core #(
    .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
  ) u_core (
    .clk(clk), .rst_n(rst_n),
    .hw_fall(hw_fall), .hr_fall(hr_fall),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctl_addr(ctl_addr), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq));

endmodule

// File: tb/kbd_host_if_test.sv
`timescale 1ns/1ps
module kbd_host_if_test;
  localparam int AW = 10;
  localparam logic [AW-1:0] DP = 10'h060;
  localparam logic [AW-1:0] CP = 10'h064;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, ctl_wdata = '0, ctl_rdata;
  logic bus_rd_n = 1, bus_wr_n = 1, ctl_wr = 0, ctl_rd = 0, kbd_irq, aux_irq;
  logic [1:0] ctl_addr = '0;

  kbd_host_if #(.ADDR_W(AW), .SYNC_STAGES(3), .DATA_PORT(DP), .CMD_PORT(CP)) uut (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // Bench model
  logic [7:0] m_obuf = 0, m_ibuf = 0;
  bit m_obf, m_ibf, m_cd, m_aux, m_kirq, m_airq, m_auto, m_irqen, m_auxsel;

  function automatic logic [7:0] exp_status();
    logic [7:0] s = 8'h00;
    s[0] = m_obf; s[1] = m_ibf; s[3] = m_cd; s[5] = m_aux;
    return s;
  endfunction

  function automatic logic [7:0] exp_ctrl();
    return {5'b0, m_auxsel, m_irqen, m_auto};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic host_op(input bit wr, input logic [AW-1:0] a,
                         input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    bus_addr = a; bus_wdata = d;
    if (wr) bus_wr_n = 0; else bus_rd_n = 0;
    repeat (6) @(negedge clk);
    rd = bus_rdata;
    bus_wr_n = 1; bus_rd_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic ctl_op(input bit wr, input bit rd, input logic [1:0] a,
                        input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    ctl_addr = a; ctl_wdata = d; ctl_wr = wr; ctl_rd = rd;
    #1 q = ctl_rdata;
    @(negedge clk);
    ctl_wr = 0; ctl_rd = 0;
  endtask

  task automatic peek(input string req);
    @(negedge clk);
    ctl_addr = 2'd1;
    #1;
    chk(req, ctl_rdata, exp_status());
    chk(req, {6'b0, aux_irq, kbd_irq}, {6'b0, m_airq, m_kirq});
  endtask

  // Model actions
  task automatic m_host_wr(input bit cmd, input logic [7:0] d);
    m_ibuf = d; m_ibf = 1; m_cd = cmd;
  endtask
  task automatic m_obuf_wr(input logic [7:0] d);
    m_obuf = d; m_obf = 1; m_aux = m_auxsel;
    m_kirq = m_irqen && !m_auxsel; m_airq = m_irqen && m_auxsel;
  endtask
  task automatic m_clear();
    m_obf = 0; m_aux = 0; m_kirq = 0; m_airq = 0;
  endtask

  // Scenario wrappers
  task automatic do_host_wr(input bit cmd, input logic [7:0] d, input string req);
    logic [7:0] r;
    host_op(1, cmd ? CP : DP, d, r);
    m_host_wr(cmd, d);
    peek(req);
  endtask

  task automatic do_data_rd(input string req);
    logic [7:0] r;
    host_op(0, DP, 8'h00, r);
    chk({req, " data"}, r, m_obuf);
    if (m_auto) m_clear();
    peek(req);
  endtask

  task automatic do_obuf_wr(input logic [7:0] d);
    logic [7:0] q;
    ctl_op(1, 0, 2'd0, d, q);
    m_obuf_wr(d);
    peek("R6");
  endtask

  task automatic do_ctrl(input logic [7:0] d);
    logic [7:0] q;
    ctl_op(1, 0, 2'd2, d, q);
    m_auto = d[0]; m_irqen = d[1]; m_auxsel = d[2];
    ctl_op(0, 0, 2'd2, 8'h00, q);
    chk("R11 ctrl readback", q, exp_ctrl());
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, q;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state
    peek("R1");
    bus_addr = DP; #1 chk("R1 obuf", bus_rdata, 8'h00);
    ctl_op(0, 0, 2'd2, 8'h00, q); chk("R1 ctrl", q, 8'h00);
    ctl_op(0, 0, 2'd0, 8'h00, q); chk("R1 ibuf", q, 8'h00);
    ctl_op(0, 0, 2'd3, 8'h00, q); chk("R11 addr3", q, 8'h00);

    // R3 / R4 / R5
    do_host_wr(0, 8'hA5, "R3");
    ctl_op(0, 1, 2'd0, 8'h00, q); chk("R5 ibuf", q, 8'hA5); m_ibf = 0; peek("R5");
    do_host_wr(1, 8'h3C, "R4");
    ctl_op(0, 0, 2'd0, 8'h00, q); chk("R4 ibuf", q, 8'h3C);

    // R6 irq disabled, then enabled kbd, overwrite keeps OBF
    do_ctrl(8'h00);
    do_obuf_wr(8'h11);
    do_ctrl(8'h03);
    do_obuf_wr(8'h22);
    do_obuf_wr(8'h33);
    // R9 status read has no effect
    host_op(0, CP, 8'h00, r); chk("R9 status", r, exp_status()); peek("R9");
    // R7 auto clear
    do_data_rd("R7");
    // R6 aux route, R7 no auto clear
    do_ctrl(8'h06);
    do_obuf_wr(8'h44);
    do_data_rd("R7 off");
    // R8 software clear
    ctl_op(1, 0, 2'd3, 8'h00, q); m_clear(); peek("R8");
    // R2 unmapped access
    host_op(1, 10'h061, 8'h99, r); peek("R2 unmapped wr");
    ctl_op(0, 0, 2'd0, 8'h00, q); chk("R2 ibuf kept", q, m_ibuf);
    host_op(0, 10'h1FF, 8'h00, r); chk("R2 unmapped rd", r, 8'hFF);

    // R10: strobe held low acts once
    do_ctrl(8'h03);
    do_obuf_wr(8'h55);
    @(negedge clk); bus_addr = DP; bus_rd_n = 0;
    repeat (6) @(negedge clk);
    m_clear(); peek("R10 first");
    ctl_op(1, 0, 2'd0, 8'h66, q); m_obuf_wr(8'h66);
    repeat (10) @(negedge clk);
    peek("R10 held");
    bus_rd_n = 1; repeat (6) @(negedge clk);
    peek("R10 release");

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 9;
      logic [7:0] d = 8'($urandom);
      case (op)
        0: do_host_wr(0, d, "R3");
        1: do_host_wr(1, d, "R4");
        2: do_data_rd("R7");
        3: begin host_op(0, CP, 0, r); chk("R2 status", r, exp_status()); peek("R9"); end
        4: do_obuf_wr(d);
        5: begin ctl_op(0, 1, 2'd0, 0, q); chk("R5", q, m_ibuf); m_ibf = 0; peek("R5"); end
        6: do_ctrl({5'b0, d[2:0]});
        7: begin ctl_op(1, 0, 2'd3, 0, q); m_clear(); peek("R8"); end
        default: begin
          logic [AW-1:0] a = AW'($urandom);
          if (a == DP || a == CP) a = 10'h2AA;
          host_op(d[0], a, d, r);
          if (!d[0]) chk("R2 unmapped rd", r, 8'hFF);
          peek("R2");
        end
      endcase
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule